// File: doc/BRIEF.md
# Register Bank CRC Integrity Monitor

This block holds a small bank of 8-bit configuration registers and watches them for silent corruption. After reset it fills the bank from a constant default table, one byte per clock. While it does so, it runs an 8-bit CRC over that table and compares the result with a check byte stored at the end of the table. Any write then triggers a fresh reference CRC over the whole bank. A tick counter periodically launches a background recomputation, which is compared with that reference.

A mismatch raises a sticky flag. There is one flag for the default table and one for the live registers. The block corrects nothing; only a reset clears the flags and reloads the defaults. The host side is reduced to a write strobe and a registered read port. A separate upset port models a bit flip in a stored register, so that the detection path can be exercised.

The CRC uses the polynomial x^8+x^2+x+1 (0x07) with initial value 0x00. Bits are taken MSB first, one byte per clock, from address 0 up to NREG-1.

Top module: `regbank_crc_monitor`

## Requirements
- R1: Reset is synchronous and active high. While reset is high, and in the first cycle after it is released, `rom_err` and `mem_err` are low and `busy` is high.
- R2: After reset is released, the registers are loaded from the default table in ascending address order, one per cycle. The default of register i is (29*i + 60) mod 256. Writes presented during this load phase are discarded.
- R3: During the load phase, a CRC over the NREG default bytes is compared with the table's stored check byte. A mismatch sets `rom_err` at the end of the load phase. `rom_err` does not change at any other time. Setting parameter ROM_CRC_FLIP to a nonzero value models a corrupted check byte.
- R4: After the load phase, and after every accepted write, a reference CRC is computed over NREG cycles with `busy` high. From reset release until `busy` falls takes exactly 2*NREG cycles. After a write, `busy` falls exactly NREG cycles after the write edge.
- R5: A write (`wr_en` high at a clock edge) stores `wr_data` into register `wr_addr`. `rd_data` shows register `rd_addr` one clock after the address is presented.
- R6: After TICK_PERIOD consecutive idle cycles, a background check starts. It lasts NREG cycles with `busy` high.
- R7: When a background check's CRC differs from the reference, `mem_err` is set at the edge that ends the check. A check over an unchanged bank leaves `mem_err` low.
- R8: A write accepted while a check or reference computation is running aborts it and restarts the reference computation. The aborted check makes no comparison.
- R9: Both flags stay set until reset, even if later writes refresh the reference. Reset clears them and restores every register to its default.
- R10: The upset port XORs `upset_mask` into register `upset_addr` without touching the reference. A write to the same address in the same cycle takes precedence over the upset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | 8 | Write data |
| upset_en | input | 1 | Apply a modelled bit flip |
| upset_addr | input | AW | Register hit by the flip |
| upset_mask | input | 8 | Bits to invert |
| rd_addr | input | AW | Read address |
| rd_data | output | 8 | Registered read data |
| busy | output | 1 | Load, reference or check walk in progress |
| rom_err | output | 1 | Sticky default-table CRC mismatch |
| mem_err | output | 1 | Sticky register-bank CRC mismatch |

## Verification
Each result has a fixed due cycle. Read data appears one edge after the address. `busy` falls 2*NREG edges after reset release, and NREG edges after a write edge. A check begins TICK_PERIOD idle edges after `busy` falls and lasts NREG edges, and `mem_err` can only move on that final edge. The bench drives inputs at falling edges or 1 ns after a rising edge, and samples 1 ns after each rising edge. It counts edges to measure these durations exactly. Read checks go through a queue whose entries are popped on the edge after the address was issued. Flag checks wait for a complete `busy` rise and fall before sampling.

// File: rtl/crc_mon_pkg.sv
package crc_mon_pkg;

  localparam logic [7:0] CRC_POLY = 8'h07;

  typedef enum logic [1:0] {
    ST_LOAD = 2'd0,
    ST_REF  = 2'd1,
    ST_IDLE = 2'd2,
    ST_CHK  = 2'd3
  } walk_state_t;

  // One byte through the CRC-8, MSB first.
  function automatic logic [7:0] crc8_step(input logic [7:0] acc, input logic [7:0] din);
    logic [7:0] x;
    x = acc ^ din;
    for (int b = 0; b < 8; b++) begin
      x = x[7] ? ((x << 1) ^ CRC_POLY) : (x << 1);
    end
    return x;
  endfunction

  function automatic logic [7:0] default_byte(input int i);
    return 8'((29 * i + 60) % 256);
  endfunction

  function automatic logic [7:0] default_crc(input int n);
    logic [7:0] c;
    c = 8'h00;
    for (int i = 0; i < n; i++) begin
      c = crc8_step(c, default_byte(i));
    end
    return c;
  endfunction

endpackage

// File: rtl/crc8_engine.sv
module crc8_engine (
  input  logic       clk,
  input  logic       rst,
  input  logic       step_en,
  input  logic       first,
  input  logic [7:0] din,
  output logic [7:0] crc_next
);
  import crc_mon_pkg::*;

  logic [7:0] crc_q;

  assign crc_next = crc8_step(first ? 8'h00 : crc_q, din);

  always_ff @(posedge clk) begin
    if (rst) begin
      crc_q <= 8'h00;
    end else if (step_en) begin
      crc_q <= crc_next;
    end
  end
endmodule

// File: rtl/crc_mon_regfile.sv
module crc_mon_regfile #(
  parameter int NREG = 16,
  parameter int AW   = 4
) (
  input  logic          clk,
  input  logic          load_en,
  input  logic [AW-1:0] load_idx,
  input  logic [7:0]    load_byte,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          upset_en,
  input  logic [AW-1:0] upset_addr,
  input  logic [7:0]    upset_mask,
  input  logic [AW-1:0] scan_idx,
  output logic [7:0]    scan_byte,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  logic [7:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (load_en && load_idx == AW'(g)) begin
        regs[g] <= load_byte;
      end else if (wr_en && !load_en && wr_addr == AW'(g)) begin
        regs[g] <= wr_data;
      end else if (upset_en && upset_addr == AW'(g)) begin
        regs[g] <= regs[g] ^ upset_mask;
      end
    end
  end

  assign scan_byte = regs[scan_idx];

  always_ff @(posedge clk) begin
    rd_data <= regs[rd_addr];
  end
endmodule

// File: rtl/crc_mon_seq.sv
module crc_mon_seq #(
  parameter int         NREG         = 16,
  parameter int         AW           = 4,
  parameter int         TICK_PERIOD  = 1024,
  parameter logic [7:0] ROM_CRC_FLIP = 8'h00
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [7:0]    scan_byte,
  input  logic [7:0]    crc_next,
  output logic          step_en,
  output logic          first,
  output logic [7:0]    crc_din,
  output logic [AW-1:0] idx,
  output logic          load_active,
  output logic [7:0]    load_byte,
  output logic          busy,
  output logic          rom_err,
  output logic          mem_err
);
  import crc_mon_pkg::*;

  localparam int            TW    = $clog2(TICK_PERIOD);
  localparam logic [AW-1:0] LAST  = AW'(NREG - 1);
  localparam logic [TW-1:0] TLAST = TW'(TICK_PERIOD - 1);

  // Default table: NREG values followed by their check byte.
  logic [7:0] rom_mem [NREG+1];
  for (genvar g = 0; g < NREG; g++) begin : g_rom
    assign rom_mem[g] = default_byte(g);
  end
  assign rom_mem[NREG] = default_crc(NREG) ^ ROM_CRC_FLIP;

  walk_state_t   state;
  logic [TW-1:0] tick;
  logic [7:0]    ref_crc;
  logic          last;

  assign last        = (idx == LAST);
  assign load_active = (state == ST_LOAD);
  assign busy        = (state != ST_IDLE);
  assign step_en     = busy;
  assign first       = (idx == '0);
  assign load_byte   = rom_mem[idx];
  assign crc_din     = load_active ? load_byte : scan_byte;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_LOAD;
      idx     <= '0;
      tick    <= '0;
      ref_crc <= 8'h00;
      rom_err <= 1'b0;
      mem_err <= 1'b0;
    end else if (state == ST_LOAD) begin
      if (last) begin
        if (crc_next != rom_mem[NREG]) rom_err <= 1'b1;
        state <= ST_REF;
        idx   <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end else if (wr_en) begin
      state <= ST_REF;
      idx   <= '0;
      tick  <= '0;
    end else begin
      case (state)
        ST_REF: begin
          if (last) begin
            ref_crc <= crc_next;
            state   <= ST_IDLE;
            idx     <= '0;
            tick    <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_IDLE: begin
          if (tick == TLAST) begin
            state <= ST_CHK;
            idx   <= '0;
            tick  <= '0;
          end else begin
            tick <= tick + 1'b1;
          end
        end
        ST_CHK: begin
          if (last) begin
            if (crc_next != ref_crc) mem_err <= 1'b1;
            state <= ST_IDLE;
            idx   <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/regbank_crc_monitor.sv
module regbank_crc_monitor #(
  parameter  int         NREG         = 16,
  parameter  int         TICK_PERIOD  = 1024,
  parameter  logic [7:0] ROM_CRC_FLIP = 8'h00,
  localparam int         AW           = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          upset_en,
  input  logic [AW-1:0] upset_addr,
  input  logic [7:0]    upset_mask,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic          busy,
  output logic          rom_err,
  output logic          mem_err
);
  logic          step_en;
  logic          first;
  logic [7:0]    crc_din;
  logic [7:0]    crc_next;
  logic [AW-1:0] idx;
  logic          load_active;
  logic [7:0]    load_byte;
  logic [7:0]    scan_byte;

  crc_mon_seq #(
    .NREG(NREG), .AW(AW), .TICK_PERIOD(TICK_PERIOD), .ROM_CRC_FLIP(ROM_CRC_FLIP)
  ) u_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .scan_byte(scan_byte), .crc_next(crc_next),
    .step_en(step_en), .first(first), .crc_din(crc_din), .idx(idx),
    .load_active(load_active), .load_byte(load_byte), .busy(busy),
    .rom_err(rom_err), .mem_err(mem_err)
  );

  crc8_engine u_crc (
    .clk(clk), .rst(rst), .step_en(step_en), .first(first), .din(crc_din),
    .crc_next(crc_next)
  );

  crc_mon_regfile #(.NREG(NREG), .AW(AW)) u_regs (
    .clk(clk), .load_en(load_active), .load_idx(idx), .load_byte(load_byte),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .upset_en(upset_en), .upset_addr(upset_addr), .upset_mask(upset_mask),
    .scan_idx(idx), .scan_byte(scan_byte), .rd_addr(rd_addr), .rd_data(rd_data)
  );
endmodule

// File: rtl/regbank_crc_monitor_chk.sv
module regbank_crc_monitor_chk (
  input logic clk,
  input logic rst,
  input logic wr_en,
  input logic busy,
  input logic loading,
  input logic rom_err,
  input logic mem_err
);
  a_r1_clean_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!rom_err && !mem_err && busy));

  a_r3_rom_flag_moves_only_in_load: assert property (@(posedge clk) disable iff (rst)
    !loading |=> $stable(rom_err));

  a_r7_mem_flag_after_walk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_err) |-> $past(busy));

  a_r8_write_restarts_walk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !loading) |=> busy);

  a_r9_mem_err_sticky: assert property (@(posedge clk) disable iff (rst)
    mem_err |=> mem_err);

  a_r9_rom_err_sticky: assert property (@(posedge clk) disable iff (rst)
    rom_err |=> rom_err);
endmodule

bind regbank_crc_monitor regbank_crc_monitor_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .busy(busy), .loading(load_active),
  .rom_err(rom_err), .mem_err(mem_err)
);

// File: tb/tb_regbank_crc_monitor.sv
module tb_regbank_crc_monitor;
  localparam int NREG = 8;
  localparam int TICK = 40;
  localparam int AW   = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic          upset_en = 1'b0;
  logic [AW-1:0] upset_addr = '0;
  logic [7:0]    upset_mask = '0;
  logic [AW-1:0] rd_addr = '0;
  logic          rd_req = 1'b0;
  logic [7:0]    rd_data, rd_data_b;
  logic          busy, busy_b, rom_err, rom_err_b, mem_err, mem_err_b;

  int total = 0;
  int bad   = 0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sbq[$];

  always #2 clk = ~clk;

  regbank_crc_monitor #(.NREG(NREG), .TICK_PERIOD(TICK), .ROM_CRC_FLIP(8'h00)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .upset_en(upset_en), .upset_addr(upset_addr), .upset_mask(upset_mask),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .rom_err(rom_err), .mem_err(mem_err)
  );

  regbank_crc_monitor #(.NREG(NREG), .TICK_PERIOD(TICK), .ROM_CRC_FLIP(8'h01)) dut_rom (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .upset_en(upset_en), .upset_addr(upset_addr), .upset_mask(upset_mask),
    .rd_addr(rd_addr), .rd_data(rd_data_b), .busy(busy_b), .rom_err(rom_err_b),
    .mem_err(mem_err_b)
  );

  function automatic logic [7:0] dflt(input int i);
    return 8'((29 * i + 60) % 256);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  // Driver side of the read scoreboard.
  task automatic rd_expect(input logic [AW-1:0] a, input logic [7:0] e, input string tag);
    item_t it;
    @(negedge clk);
    rd_addr = a;
    rd_req  = 1'b1;
    it.exp  = e;
    it.tag  = tag;
    sbq.push_back(it);
  endtask

  task automatic rd_flush();
    @(negedge clk);
    rd_req = 1'b0;
    @(negedge clk);
  endtask

  // Monitor side: data is due one edge after the address.
  always @(posedge clk) begin
    if (rd_req) begin
      #1;
      if (sbq.size() == 0) begin
        chk("scoreboard underflow", 32'd1, 32'd0);
      end else begin
        item_t it;
        it = sbq.pop_front();
        chk(it.tag, {24'd0, rd_data}, {24'd0, it.exp});
      end
    end
  end

  task automatic do_write(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_upset(input logic [AW-1:0] a, input logic [7:0] m);
    @(negedge clk);
    upset_en = 1'b1; upset_addr = a; upset_mask = m;
    @(negedge clk);
    upset_en = 1'b0;
  endtask

  task automatic wait_idle();
    do begin @(posedge clk); #1; end while (busy);
  endtask

  task automatic wait_busy();
    do begin @(posedge clk); #1; end while (!busy);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 mem_err in reset", {31'd0, mem_err}, 32'd0);
    chk("R9 mem_err cleared by reset", {31'd0, mem_err}, 32'd0);
    rst = 1'b0;
    wait_idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    int n;
    repeat (4) @(negedge clk);
    chk("R1 busy in reset", {31'd0, busy}, 32'd1);
    chk("R1 rom_err in reset", {31'd0, rom_err}, 32'd0);
    chk("R1 mem_err in reset", {31'd0, mem_err}, 32'd0);
    chk("R1 rom_err_b in reset", {31'd0, rom_err_b}, 32'd0);
    rst = 1'b0;

    // R4 start-up duration; R2 write during load phase must be dropped.
    n = 0;
    for (int k = 1; k <= 100; k++) begin
      @(posedge clk); #1;
      if (k == 2) begin wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'hAA; end
      if (k == 3) wr_en = 1'b0;
      if (!busy) begin n = k; break; end
    end
    chk("R4 cycles from reset release to idle", n, 2 * NREG);
    chk("R3 rom_err with intact table", {31'd0, rom_err}, 32'd0);
    chk("R3 rom_err with corrupted check byte", {31'd0, rom_err_b}, 32'd1);
    chk("R7 mem_err after load", {31'd0, mem_err}, 32'd0);

    for (int i = 0; i < NREG; i++) rd_expect(AW'(i), dflt(i), $sformatf("R2 default reg %0d", i));
    rd_flush();

    // R4 reference duration after a write, R5 readback.
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd2; wr_data = 8'h5A;
    @(posedge clk); #1;
    wr_en = 1'b0;
    chk("R4 busy after write edge", {31'd0, busy}, 32'd1);
    n = 0;
    do begin @(posedge clk); #1; n++; end while (busy);
    chk("R4 reference walk length", n, NREG);

    // R6 idle interval and check length.
    n = 0;
    do begin @(posedge clk); #1; n++; end while (!busy);
    chk("R6 idle cycles before check", n, TICK);
    n = 0;
    do begin @(posedge clk); #1; n++; end while (busy);
    chk("R6 check walk length", n, NREG);
    chk("R7 clean check leaves mem_err low", {31'd0, mem_err}, 32'd0);
    rd_expect(3'd2, 8'h5A, "R5 write readback");
    rd_flush();

    // R10 upset visible, R7 detected only after the next check.
    do_upset(3'd4, 8'h10);
    rd_expect(3'd4, dflt(4) ^ 8'h10, "R10 upset flips bits");
    rd_flush();
    chk("R7 no flag before check runs", {31'd0, mem_err}, 32'd0);
    wait_busy();
    wait_idle();
    chk("R7 mismatch sets mem_err", {31'd0, mem_err}, 32'd1);

    // R9 sticky across a refreshed reference.
    do_write(3'd4, 8'h33);
    wait_idle();
    wait_busy();
    wait_idle();
    chk("R9 mem_err stays set", {31'd0, mem_err}, 32'd1);
    chk("R9 rom_err stays set", {31'd0, rom_err_b}, 32'd1);

    do_reset();
    chk("R9 mem_err low after reset", {31'd0, mem_err}, 32'd0);
    chk("R3 rom_err_b set again after reset", {31'd0, rom_err_b}, 32'd1);
    rd_expect(3'd4, dflt(4), "R9 reg 4 reloaded");
    rd_expect(3'd2, dflt(2), "R9 reg 2 reloaded");
    rd_flush();

    // R8 a write during a check aborts it.
    do_upset(3'd6, 8'h01);
    wait_busy();
    do_write(3'd1, 8'h77);
    wait_idle();
    wait_busy();
    wait_idle();
    chk("R8 aborted check made no comparison", {31'd0, mem_err}, 32'd0);
    rd_expect(3'd1, 8'h77, "R8 write during check stored");
    rd_expect(3'd6, dflt(6) ^ 8'h01, "R10 upset kept");
    rd_flush();

    // R10 write wins over an upset at the same address.
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd7; wr_data = 8'h0F;
    upset_en = 1'b1; upset_addr = 3'd7; upset_mask = 8'hFF;
    @(negedge clk);
    wr_en = 1'b0; upset_en = 1'b0;
    rd_expect(3'd7, 8'h0F, "R10 write beats upset");
    rd_flush();
    wait_idle();

    chk("scoreboard drained", sbq.size(), 0);
    summary();
    $finish;
  end
endmodule